// File: doc/BRIEF.md
# Timestamp to Correction-Field Expander

This block turns a 32-bit packet timestamp into a signed 64-bit correction-field value. The timestamp counts in steps of 2^-8 ns. The correction field counts in steps of 2^-16 ns. The 32 timestamp bits fill the middle of the field, and the eight bits below them are zero, because the timer does not resolve time that finely. The bits above the timestamp are rebuilt from a wider reference value of the free-running system timer. That reference is sampled close to the moment of capture, either shortly before it or shortly after it.

The reference low word may have rolled over the 32-bit window between capture and sampling. For this reason the upper part is not copied unchanged. It is corrected by plus or minus one when a wrap is detected. A direction input tells the block whether the capture came before or after the reference sample. The same conversion serves both paths: stamps written into a packet as it passes, and stamps reported afterwards. The result is registered and comes out one cycle after the input strobe.

Top module: `cf_expander`

## Requirements
- R1: Reset clears `out_valid` and `out_cf` to zero. After reset, `out_valid` is high in the cycle that follows a cycle with `in_valid` high, and low otherwise.
- R2: Bits [7:0] of `out_cf` are always zero.
- R3: Bits [39:8] of `out_cf` equal the `in_ts` value that was presented with the accepted strobe.
- R4: When `in_cap_after` is 0 (capture precedes the reference), the upper part is `in_ref[54:32]` minus one if `in_ts` is greater than `in_ref[31:0]`. Otherwise it is `in_ref[54:32]` unchanged.
- R5: When `in_cap_after` is 1 (capture follows the reference), the upper part is `in_ref[54:32]` plus one if `in_ts` is less than `in_ref[31:0]`. Otherwise it is `in_ref[54:32]` unchanged.
- R6: When `in_ts` equals `in_ref[31:0]`, the upper part equals `in_ref[54:32]` in both directions.
- R7: The upper part is placed in `out_cf[62:40]`, and `out_cf[63]` is zero. The plus-one and minus-one adjustments wrap modulo 2^23.
- R8: While `in_valid` is low, `out_cf` keeps its previous value.
- R9: A time of 2.5 ns, given with zero upper bits, produces `64'h0000_0000_0002_8000`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_valid | input | 1 | Strobe: convert the inputs in this cycle |
| in_ts | input | 32 | Truncated capture time in 2^-8 ns units |
| in_ref | input | 55 | System timer reference in 2^-8 ns units |
| in_cap_after | input | 1 | 1 = capture follows the reference sample, 0 = capture precedes it |
| out_valid | output | 1 | Result strobe, one cycle after `in_valid` |
| out_cf | output | 64 | Correction-field value in 2^-16 ns units |

## Verification
The wrap rules are correct only if the reference lies less than half of the 32-bit window away from the capture, on the side that `in_cap_after` names. The assertions take that as given and check only the mapping: field placement, the strobe delay, holding when idle, and the equal-low-word case. The directed stimulus always places the reference a few steps to the stated side of the timestamp. Some of these cases straddle the 2^32 boundary and some do not, and two of them push the 23-bit upper part across its own modulus.

// File: rtl/cf_pkg.sv
// Package cf_pkg: widths shared by the correction-field expander.
// Assumes the timestamp and reference use the same 2^-8 ns unit.
package cf_pkg;
    localparam int TS_W  = 32;  // truncated timestamp width
    localparam int PAD_W = 8;   // zero bits below the supported precision
    localparam int REF_W = 55;  // reference timer width
    localparam int CF_W  = 64;  // correction field width

    // Upper-part adjustment chosen by the wrap detector.
    typedef enum logic [1:0] {
        ADJ_KEEP = 2'b00,
        ADJ_DEC  = 2'b01,
        ADJ_INC  = 2'b10
    } adj_e;
endpackage

// File: rtl/cf_wrap_detect.sv
// Module cf_wrap_detect: compares the timestamp with the low word of the
// reference and decides whether the reference upper part must move by one.
// Assumes capture and reference are less than half a window apart.
module cf_wrap_detect
    import cf_pkg::*;
#(
    parameter int W = TS_W
) (
    input  logic [W-1:0] ts,
    input  logic [W-1:0] ref_lo,
    input  logic         cap_after,
    output adj_e         adj
);
    // Pick the correction from the direction and the low-word ordering.
    always_comb begin
        adj = ADJ_KEEP;
        if (cap_after) begin
            if (ts < ref_lo) adj = ADJ_INC;
        end else begin
            if (ts > ref_lo) adj = ADJ_DEC;
        end
    end
endmodule

// File: rtl/cf_upper_adjust.sv
// Module cf_upper_adjust: applies the chosen +1 / -1 / none correction to
// the reference upper part, modulo 2^W.
// Assumes the adjustment code is one of the three legal values.
module cf_upper_adjust
    import cf_pkg::*;
#(
    parameter int W = REF_W - TS_W
) (
    input  logic [W-1:0] up_in,
    input  adj_e         adj,
    output logic [W-1:0] up_out
);
    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    // Add, subtract or pass the upper part.
    always_comb begin
        unique case (adj)
            ADJ_INC: up_out = up_in + ONE;
            ADJ_DEC: up_out = up_in - ONE;
            default: up_out = up_in;
        endcase
    end
endmodule

// File: rtl/cf_expander.sv
// Module cf_expander: builds a registered correction field from a 32-bit
// timestamp and a wider timer reference. The upper part is wrap-corrected,
// the timestamp fills the middle and the lowest bits are zero.
// Assumes the reference is taken within a short datapath latency of capture.
module cf_expander
    import cf_pkg::*;
#(
    parameter int TSW  = TS_W,
    parameter int PADW = PAD_W,
    parameter int REFW = REF_W,
    parameter int CFW  = CF_W
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_valid,
    input  logic [TSW-1:0]  in_ts,
    input  logic [REFW-1:0] in_ref,
    input  logic            in_cap_after,
    output logic            out_valid,
    output logic [CFW-1:0]  out_cf
);
    localparam int UP_W  = REFW - TSW;          // upper part from reference
    localparam int HI_W  = CFW - TSW - PADW;    // field bits above timestamp
    localparam int TS_LO = PADW;                // lowest timestamp bit in field
    localparam int HI_LO = PADW + TSW;          // lowest upper bit in field

    adj_e              adj;
    logic [UP_W-1:0]   up_fix;
    logic [HI_W-1:0]   hi_ext;
    logic [CFW-1:0]    cf_next;

    cf_wrap_detect #(.W(TSW)) u_detect (
        .ts        (in_ts),
        .ref_lo    (in_ref[TSW-1:0]),
        .cap_after (in_cap_after),
        .adj       (adj)
    );

    cf_upper_adjust #(.W(UP_W)) u_adjust (
        .up_in  (in_ref[REFW-1:TSW]),
        .adj    (adj),
        .up_out (up_fix)
    );

    // Widen the corrected upper part to the field width, zero-filling the top.
    generate
        if (HI_W > UP_W) begin : g_pad
            assign hi_ext = {{(HI_W-UP_W){1'b0}}, up_fix};
        end else begin : g_trim
            assign hi_ext = up_fix[HI_W-1:0];
        end
    endgenerate

    // Assemble the field: upper part, timestamp, zero padding.
    always_comb begin
        cf_next = {hi_ext, in_ts, {PADW{1'b0}}};
    end

    // Register the result and its strobe; hold the result when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_cf    <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) out_cf <= cf_next;
        end
    end

    // ---------------- assertions ----------------
    assert_valid_follows_R1: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_valid);
    assert_valid_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> !out_valid);
    assert_pad_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        out_cf[PADW-1:0] == '0);
    assert_ts_placed_R3: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid |=> out_cf[HI_LO-1:TS_LO] == $past(in_ts));
    assert_equal_keeps_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ts == in_ref[TSW-1:0])
        |=> out_cf[HI_LO+UP_W-1:HI_LO] == $past(in_ref[REFW-1:TSW]));
    assert_hold_idle_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(out_cf));
    assert_adj_legal_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(adj));
endmodule

// File: tb/cf_expander_tb.sv
module cf_expander_tb;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_valid;
    logic [31:0] in_ts;
    logic [54:0] in_ref;
    logic        in_cap_after;
    logic        out_valid;
    logic [63:0] out_cf;

    int total = 0;
    int bad   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cf_expander u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .in_valid     (in_valid),
        .in_ts        (in_ts),
        .in_ref       (in_ref),
        .in_cap_after (in_cap_after),
        .out_valid    (out_valid),
        .out_cf       (out_cf)
    );

    // Expected field computed from the requirements (R4, R5, R7).
    function automatic logic [63:0] model(input logic [31:0] ts,
                                          input logic [22:0] up,
                                          input logic [31:0] lo,
                                          input logic after);
        logic [22:0] h;
        h = up;
        if (after && ts < lo)  h = up + 23'd1;
        if (!after && ts > lo) h = up - 23'd1;
        return {1'b0, h, ts, 8'h00};
    endfunction

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Present one conversion at a negedge, check it one cycle later.
    task automatic convert(input string req, input logic [31:0] ts,
                           input logic [22:0] up, input logic [31:0] lo,
                           input logic after);
        @(negedge clk);
        in_valid = 1'b1; in_ts = ts; in_ref = {up, lo}; in_cap_after = after;
        @(negedge clk);
        in_valid = 1'b0;
        check({req, " valid"}, {63'd0, out_valid}, 64'd1);
        check(req, out_cf, model(ts, up, lo, after));
    endtask

    task automatic t_reset;
        check("R1 reset valid", {63'd0, out_valid}, 64'd0);
        check("R1 reset cf", out_cf, 64'd0);
    endtask

    task automatic t_two_and_half;
        convert("R9 2.5ns", 32'h280, 23'd0, 32'h280, 1'b0);
        check("R9 literal", out_cf, 64'h0000_0000_0002_8000);
    endtask

    task automatic t_before;
        convert("R4 no wrap", 32'h0000_0008, 23'd5, 32'h0000_0010, 1'b0);
        convert("R4 wrap", 32'hFFFF_FFF0, 23'd5, 32'h0000_0010, 1'b0);
        check("R4 upper", {41'd0, out_cf[62:40]}, 64'd4);
    endtask

    task automatic t_after;
        convert("R5 no wrap", 32'h0000_0020, 23'd5, 32'h0000_0010, 1'b1);
        convert("R5 wrap", 32'h0000_0010, 23'd5, 32'hFFFF_FFF0, 1'b1);
        check("R5 upper", {41'd0, out_cf[62:40]}, 64'd6);
    endtask

    task automatic t_equal;
        convert("R6 before", 32'h1234_5678, 23'h00ABCD, 32'h1234_5678, 1'b0);
        convert("R6 after", 32'h1234_5678, 23'h00ABCD, 32'h1234_5678, 1'b1);
        check("R6 upper", {41'd0, out_cf[62:40]}, 64'h00ABCD);
    endtask

    task automatic t_modulo;
        convert("R7 dec wrap", 32'hFFFF_FF00, 23'd0, 32'h0000_0004, 1'b0);
        check("R7 dec top", {41'd0, out_cf[62:40]}, 64'h7FFFFF);
        check("R7 sign", {63'd0, out_cf[63]}, 64'd0);
        convert("R7 inc wrap", 32'h0000_0004, 23'h7FFFFF, 32'hFFFF_FF00, 1'b1);
        check("R7 inc top", {41'd0, out_cf[62:40]}, 64'd0);
    endtask

    task automatic t_hold;
        logic [63:0] prev;
        convert("R3 place", 32'hCAFE_BABE, 23'h12345, 32'hCAFE_BAB0, 1'b1);
        check("R3 middle", {32'd0, out_cf[39:8]}, 64'hCAFE_BABE);
        check("R2 pad", {56'd0, out_cf[7:0]}, 64'd0);
        prev = out_cf;
        @(negedge clk);
        in_valid = 1'b0; in_ts = 32'h1; in_ref = '1; in_cap_after = 1'b0;
        @(negedge clk);
        check("R8 hold", out_cf, prev);
        check("R1 idle valid", {63'd0, out_valid}, 64'd0);
    endtask

    initial begin
        rst_n = 1'b0; in_valid = 1'b0; in_ts = '0; in_ref = '0; in_cap_after = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_two_and_half();
        t_before();
        t_after();
        t_equal();
        t_modulo();
        t_hold();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule